// File: doc/BRIEF.md
# Weighted Noise Spectral Mixer

This block forms the test stimulus for one input of a sequential circuit under self-test. It receives up to three bit-streams, each carrying one significant Walsh component chosen for that input, and in every cycle of the self-test clock passes exactly one of them to the circuit input. Which stream wins in a given cycle is decided by pseudo-random bits, so the output follows the spectral shape of the components while carrying the noise that makes it look like a deterministic test sequence rather than a pure periodic wave.

The pseudo-random source is a hybrid rule 90/150 cellular-automaton register with null boundaries, started from a nonzero seed. Two of its cells are tapped: one cell on its own gives a select bit of weight one half, and AND gating of the two cells gives select bits of weight one quarter. A two-bit mode picks pass-through of one stream, an even split of two streams, or a quarter/quarter/half split of three streams. The mixed bit is registered, so it reaches the circuit one self-test clock after the inputs that produced it. How the proportions themselves are chosen is left to the surrounding generator.

Top module: `noise_spectral_mixer`

## Requirements
- R1: While `rst_n` is low, `mix_out` is 0 and the automaton holds `SEED`; the first cycle after release selects with the seed state.
- R2: On each rising edge of `clk` out of reset the automaton advances: cell i becomes cell i+1 XOR cell i-1 (cells beyond either end read as 0), further XORed with cell i when bit i of `RULE` is 1; should that next state be all zero, `SEED` is loaded instead, so the state is never all zero.
- R3: The three-way select is one-hot: stream 3 is chosen when cell `TAP_HALF` is 1; otherwise stream 1 when cell `TAP_SPLIT` is 1 and stream 2 when it is 0.
- R4: In mode 1 (`mode` = 2'b01) the output is `comp_in[1]` when cell `TAP_HALF` is 1 and `comp_in[0]` otherwise, and over 4096 cycles the second stream is taken between 1700 and 2400 times.
- R5: In mode 0 (`mode` = 2'b00) the output is `comp_in[0]` one cycle later, and `comp_in[1]` and `comp_in[2]` have no effect on it.
- R6: In modes 2 and 3 (`mode[1]` = 1) the output is the stream picked by the R3 select, with `comp_in[0]` as stream 1, `comp_in[1]` as stream 2 and `comp_in[2]` as stream 3.
- R7: In three-stream mode over 4096 cycles stream 3 is taken between 1700 and 2400 times and stream 1 between 700 and 1350 times.
- R8: `mix_out` is a register: the value chosen from the inputs and automaton state present at a rising edge appears after that edge and holds until the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Self-test clock; the automaton and the output advance on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | 00 single stream, 01 two streams, 10 or 11 three streams |
| comp_in | input | 3 | Component streams; bit 0 is stream 1, bit 2 is stream 3 |
| mix_out | output | 1 | Registered mixed bit for the circuit input |

## Verification
The mixing is tried first with a vector table that holds each mode with every component pattern that distinguishes the streams: a single high stream shows which source was picked, complementary patterns show that the others were not, and all-equal patterns show the output does not depend on the select at all. Every cycle is compared against an independent model of the automaton, so a wrong rule cell, a wrong boundary or a swapped tap shows up as a mismatch within a few cycles. Long runs with only stream 3, only stream 1 or only the second pair stream high measure the proportions, and a reset in the middle of a run shows that the sequence restarts from the seed.

// File: rtl/mixer_pkg.sv
package mixer_pkg;

  typedef enum logic [1:0] {
    MIX_SINGLE = 2'b00,
    MIX_PAIR   = 2'b01,
    MIX_TRIPLE = 2'b10,
    MIX_TRIPLE_ALT = 2'b11
  } mix_mode_e;

  localparam int unsigned NUM_STREAMS = 3;

  typedef logic [NUM_STREAMS-1:0] stream_vec_t;

  // One null-boundary hybrid cell: XOR of the neighbours, plus itself under rule 150.
  function automatic logic ca_cell_next(input logic left_nb, input logic right_nb,
                                        input logic self_bit, input logic rule150);
    return left_nb ^ right_nb ^ (rule150 & self_bit);
  endfunction

  // Picks the stream bit for a mode, given the one-hot triple select and the pair select.
  function automatic logic mix_pick(input mix_mode_e m, input stream_vec_t streams,
                                    input stream_vec_t onehot, input logic pair_hi);
    logic r;
    case (m)
      MIX_SINGLE: r = streams[0];
      MIX_PAIR:   r = pair_hi ? streams[1] : streams[0];
      default:    r = |(streams & onehot);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mixer_ca_reg.sv
module mixer_ca_reg #(
  parameter int unsigned   W    = 16,
  parameter logic [W-1:0]  RULE = 16'h6B2D,
  parameter logic [W-1:0]  SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state_q,
  output logic         wrap_hit
);
  import mixer_pkg::*;

  logic [W-1:0] nxt_raw;
  logic [W-1:0] nxt_d;

  for (genvar i = 0; i < W; i++) begin : g_cell
    logic left_nb;
    logic right_nb;
    if (i == W - 1) begin : g_top
      assign left_nb = 1'b0;
    end else begin : g_top_inner
      assign left_nb = state_q[i+1];
    end
    if (i == 0) begin : g_bot
      assign right_nb = 1'b0;
    end else begin : g_bot_inner
      assign right_nb = state_q[i-1];
    end
    assign nxt_raw[i] = ca_cell_next(left_nb, right_nb, state_q[i], RULE[i]);
  end

  assign wrap_hit = (nxt_raw == '0);
  assign nxt_d    = wrap_hit ? SEED : nxt_raw;

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= nxt_d;
  end

endmodule

// File: rtl/mixer_weight_gen.sv
module mixer_weight_gen #(
  parameter int unsigned W         = 16,
  parameter int unsigned TAP_HALF  = 5,
  parameter int unsigned TAP_SPLIT = 11
) (
  input  logic [W-1:0]             ca_state,
  output mixer_pkg::stream_vec_t   sel_onehot,
  output logic                     pair_hi
);
  logic half_bit;
  logic split_bit;
  logic quarter_a;
  logic quarter_b;

  assign half_bit  = ca_state[TAP_HALF];
  assign split_bit = ca_state[TAP_SPLIT];

  // AND gating gives weight 1/4; the OR-based term is its complement partner.
  assign quarter_a = ~half_bit & split_bit;
  assign quarter_b = ~(half_bit | split_bit);

  assign sel_onehot = {half_bit, quarter_b, quarter_a};
  assign pair_hi    = half_bit;

endmodule

// File: rtl/mixer_select.sv
module mixer_select (
  input  mixer_pkg::mix_mode_e   mode,
  input  mixer_pkg::stream_vec_t streams,
  input  mixer_pkg::stream_vec_t sel_onehot,
  input  logic                   pair_hi,
  output logic                   pick_bit
);
  import mixer_pkg::*;

  always_comb pick_bit = mix_pick(mode, streams, sel_onehot, pair_hi);

endmodule

// File: rtl/noise_spectral_mixer.sv
module noise_spectral_mixer #(
  parameter int unsigned  CA_W      = 16,
  parameter logic [CA_W-1:0] RULE   = 16'h6B2D,
  parameter logic [CA_W-1:0] SEED   = 16'hACE1,
  parameter int unsigned  TAP_HALF  = 5,
  parameter int unsigned  TAP_SPLIT = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic [2:0] comp_in,
  output logic       mix_out
);
  import mixer_pkg::*;

  logic [CA_W-1:0] ca_q;
  logic            ca_wrap;
  stream_vec_t     sel_oh;
  logic            pair_pick;
  logic            pick_bit;
  mix_mode_e       mode_e;

  assign mode_e = mix_mode_e'(mode);

  mixer_ca_reg #(.W(CA_W), .RULE(RULE), .SEED(SEED)) ca_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .state_q  (ca_q),
    .wrap_hit (ca_wrap)
  );

  mixer_weight_gen #(.W(CA_W), .TAP_HALF(TAP_HALF), .TAP_SPLIT(TAP_SPLIT)) wgt_i (
    .ca_state   (ca_q),
    .sel_onehot (sel_oh),
    .pair_hi    (pair_pick)
  );

  mixer_select sel_i (
    .mode       (mode_e),
    .streams    (comp_in),
    .sel_onehot (sel_oh),
    .pair_hi    (pair_pick),
    .pick_bit   (pick_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) mix_out <= 1'b0;
    else        mix_out <= pick_bit;
  end

endmodule

// File: rtl/noise_spectral_mixer_chk.sv
module noise_spectral_mixer_chk #(
  parameter int unsigned CA_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      mode,
  input logic [2:0]      comp_in,
  input logic            mix_out,
  input logic [CA_W-1:0] ca_q,
  input logic [2:0]      sel_oh,
  input logic            pair_pick
);

  p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> (mix_out == 1'b0));

  p_ca_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ca_q != '0);

  p_sel_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel_oh) == 1);

  p_pair_pick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |=> (mix_out == $past(pair_pick ? comp_in[1] : comp_in[0])));

  p_single_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |=> (mix_out == $past(comp_in[0])));

  p_triple_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && sel_oh[2]) |=> (mix_out == $past(comp_in[2])));

  p_triple_rest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && !sel_oh[2]) |=> (mix_out == $past(sel_oh[0] ? comp_in[0] : comp_in[1])));

endmodule

bind noise_spectral_mixer noise_spectral_mixer_chk #(.CA_W(CA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode      (mode),
  .comp_in   (comp_in),
  .mix_out   (mix_out),
  .ca_q      (ca_q),
  .sel_oh    (sel_oh),
  .pair_pick (pair_pick)
);

// File: tb/noise_spectral_mixer_tb_top.sv
`timescale 1ns/1ps
module noise_spectral_mixer_tb_top;

  localparam int unsigned W      = 16;
  localparam logic [W-1:0] RULE  = 16'h6B2D;
  localparam logic [W-1:0] SEED  = 16'hACE1;
  localparam int unsigned TH     = 5;
  localparam int unsigned TS     = 11;
  localparam int unsigned NVEC   = 16;
  localparam int unsigned RUNLEN = 4096;

  // {mode[1:0], comp_in[2:0]}
  localparam logic [4:0] VEC [NVEC] = '{
    5'b00_001, 5'b00_110, 5'b00_000, 5'b00_111,
    5'b01_001, 5'b01_010, 5'b01_011, 5'b01_100,
    5'b10_100, 5'b10_001, 5'b10_010, 5'b10_011,
    5'b11_100, 5'b11_011, 5'b11_111, 5'b11_101
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [2:0] comp_in = 3'b000;
  logic       mix_out;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 1'b0;
  logic [W-1:0] model;

  always #4 clk = ~clk;

  noise_spectral_mixer #(.CA_W(W), .RULE(RULE), .SEED(SEED), .TAP_HALF(TH), .TAP_SPLIT(TS)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .comp_in(comp_in), .mix_out(mix_out)
  );

  function automatic logic [W-1:0] ref_step(input logic [W-1:0] s);
    logic [W-1:0] n;
    n = (s >> 1) ^ (s << 1) ^ (s & RULE);
    if (n == '0) n = SEED;
    return n;
  endfunction

  function automatic logic ref_mix(input logic [1:0] m, input logic [2:0] c, input logic [W-1:0] s);
    if (m == 2'b00) return c[0];
    if (m == 2'b01) return s[TH] ? c[1] : c[0];
    if (s[TH]) return c[2];
    return s[TS] ? c[0] : c[1];
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: mix_out=%0b expected %0b (cycle %0d)", req, act, exp, cycles);
    end
  endtask

  // Drive one cycle at the falling edge, then compare at the next falling edge.
  task automatic step_cycle(input logic [1:0] m, input logic [2:0] c, input string req);
    logic e;
    mode = m;
    comp_in = c;
    e = ref_mix(m, c, model);
    model = ref_step(model);
    @(negedge clk);
    check(req, mix_out, e);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset", mix_out, 1'b0);
    rst_n = 1'b1;
    model = SEED;
  endtask

  task automatic count_run(input logic [1:0] m, input logic [2:0] c, output int ones);
    ones = 0;
    for (int k = 0; k < RUNLEN; k++) begin
      logic e;
      mode = m;
      comp_in = c;
      e = ref_mix(m, c, model);
      model = ref_step(model);
      @(negedge clk);
      if (mix_out !== e) begin
        n_fail++;
        $display("FAIL R2 sequence: mix_out=%0b expected %0b (cycle %0d)", mix_out, e, cycles);
      end
      if (mix_out === 1'b1) ones++;
    end
    n_tests++;
  endtask

  task automatic range_check(input string req, input int v, input int lo, input int hi);
    n_tests++;
    if (v < lo || v > hi) begin
      n_fail++;
      $display("FAIL %s: count=%0d expected %0d..%0d", req, v, lo, hi);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      done = 1'b1;
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: cycles=%0d expected <= 200000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int ones;
    model = SEED;
    @(negedge clk);
    do_reset();

    // R5 R4 R6 R3 R8: table walk, each vector held for three cycles.
    for (int v = 0; v < NVEC; v++) begin
      for (int r = 0; r < 3; r++) begin
        step_cycle(VEC[v][4:3], VEC[v][2:0],
                   VEC[v][4:3] == 2'b00 ? "R5 single" :
                   VEC[v][4:3] == 2'b01 ? "R4 pair" : "R6 triple");
      end
    end

    // R5: other streams toggle under single mode with stream 1 held low, then high.
    for (int k = 0; k < 8; k++) step_cycle(2'b00, {k[1:0], 1'b0}, "R5 ignore");
    for (int k = 0; k < 8; k++) step_cycle(2'b00, {k[1:0], 1'b1}, "R5 ignore");

    // R8: one-cycle latency on a mode switch.
    step_cycle(2'b10, 3'b100, "R8 latency");
    step_cycle(2'b00, 3'b000, "R8 latency");

    // R1: reset in the middle of a run restarts from the seed.
    do_reset();
    for (int k = 0; k < 6; k++) step_cycle(2'b10, 3'b001, "R1 seed restart");

    // R7 R4 R3 R2: proportions, each cycle also compared to the model.
    count_run(2'b10, 3'b100, ones);
    range_check("R7 stream3 half", ones, 1700, 2400);
    count_run(2'b10, 3'b001, ones);
    range_check("R7 stream1 quarter", ones, 700, 1350);
    count_run(2'b11, 3'b010, ones);
    range_check("R3 stream2 quarter", ones, 700, 1350);
    count_run(2'b01, 3'b010, ones);
    range_check("R4 pair half", ones, 1700, 2400);

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule